// File: doc/BRIEF.md
# Sensor Status and Result Register Bank

This block keeps the status byte and the latest conversion result of a sensing front end, and presents them to a byte-wide serial register port. A conversion-done strobe delivers a 12-bit result, a comparator flag and an active-low flag that marks an offset-DAC adjustment. The bank stores these values. The status byte also shows a live power-down indication. The bus protocol engine sits outside the block. It drives a pointer load, a per-byte read strobe and a transaction-end strobe, and it samples the byte selected by the pointer.

A two-state machine protects the integrity of the result. In `ST_OPEN`, accepted conversions update the bank. The transition `OPEN->HOLD` happens on any byte read from the result high or low address. In `ST_HOLD`, the result and status captures are frozen, and any conversion that finishes is discarded. The transition `HOLD->OPEN` happens on the transaction-end strobe. If a result byte is read in the same cycle as the end strobe, the machine stays in `ST_OPEN`, but a conversion in that cycle is still dropped. Since the pointer steps after every byte, a host can read both result bytes back to back and get two halves of the same sample.

Top module: `sreg_bank`

## Requirements
- R1: After reset the status byte (address 0x00) reads 0x53, the result bytes (0x01 and 0x02) read 0x00, and the pointer is 0x00.
- R2: Status bits 6 and 1 always read 1, and bits 5 and 2 always read 0.
- R3: An accepted conversion clears status bit 0 (ready, active low) in the next cycle. It also stores the result so that address 0x01 reads result[11:4] and address 0x02 reads {result[3:0], 4'b0000}.
- R4: An accepted conversion copies the comparator flag into status bit 3 and the active-low DAC-changed flag into status bit 4. Both bits keep their values until the next accepted conversion.
- R5: Status bit 7 follows the power-down input in the same cycle, without a register in between.
- R6: A pointer load sets the pointer to the supplied address. A read strobe without a load increments the pointer by one, wrapping from 0xFF to 0x00. When load and read occur in the same cycle, the load takes effect and the read is ignored.
- R7: A read strobe at address 0x01 or 0x02 sets the ready bit back to 1 in the next cycle. A read at 0x00 leaves the ready bit unchanged.
- R8: After a result byte is read, every conversion is discarded, including one in the same cycle as the read or the end strobe. Result bytes and status bits 0, 3 and 4 stay unchanged until the transaction-end strobe.
- R9: After the transaction-end strobe, the next conversion is accepted again.
- R10: Any address above 0x02 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| conv_done | input | 1 | One-cycle strobe that marks a finished conversion |
| conv_res | input | 12 | Conversion result, valid with conv_done |
| cmp_flag | input | 1 | Comparator output, valid with conv_done |
| dac_moved_n | input | 1 | Low when the offset DAC changed during the conversion |
| pwr_down | input | 1 | Power-down or low-supply indication |
| ptr_load | input | 1 | Load the register pointer |
| ptr_addr | input | 8 | Address for ptr_load |
| byte_rd | input | 1 | One byte consumed by the bus engine |
| xfer_end | input | 1 | Transaction-end (stop) strobe |
| rd_byte | output | 8 | Byte at the current pointer |

## Verification
Assertions check on every cycle that the pointer steps by one after each read without a load, and that an accepted conversion clears ready. They also check that a result-byte read sets ready, that the stored result stays stable while the bank is held, and that unmapped addresses return zero. The bench scenarios cover what single-cycle properties cannot show. These are the exact byte encodings for several results and flag combinations, and the dropping of a conversion that coincides with the end strobe. The bench also checks that a result read across a hold returns both halves of the older sample, the live power-down bit, and the priority of load over read.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
    typedef enum logic [0:0] {
        ST_OPEN = 1'b0,
        ST_HOLD = 1'b1
    } hold_state_t;

    localparam int unsigned ADR_STATUS = 0;
    localparam int unsigned ADR_RES_HI = 1;
    localparam int unsigned ADR_RES_LO = 2;
endpackage

// File: rtl/sreg_ptr.sv
module sreg_ptr #(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              step,
    output logic [ADDR_W-1:0] ptr
);
    logic [ADDR_W-1:0] ptr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (load)
            ptr_q <= load_addr;
        else if (step)
            ptr_q <= ptr_q + ADDR_W'(1);
    end

    assign ptr = ptr_q;

    // R6: a read without a load advances the pointer by one
    p_ptr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (ptr == $past(ptr) + ADDR_W'(1)));
endmodule

// File: rtl/sreg_hold_fsm.sv
module sreg_hold_fsm
    import sreg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic res_rd,
    input  logic xfer_end,
    output logic hold
);
    hold_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_OPEN;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OPEN: if (res_rd && !xfer_end) state_d = ST_HOLD;
            ST_HOLD: if (xfer_end)            state_d = ST_OPEN;
            default:                          state_d = ST_OPEN;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_OPEN: hold = res_rd;
            ST_HOLD: hold = 1'b1;
            default: hold = 1'b1;
        endcase
    end
endmodule

// File: rtl/sreg_store.sv
module sreg_store #(
    parameter int unsigned RES_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             conv_done,
    input  logic [RES_W-1:0] conv_res,
    input  logic             cmp_flag,
    input  logic             dac_moved_n,
    input  logic             hold,
    input  logic             res_rd,
    output logic [RES_W-1:0] res_q,
    output logic             rdy_n_q,
    output logic             cmp_q,
    output logic             dac_n_q
);
    logic accept;
    assign accept = conv_done && !hold;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q   <= '0;
            cmp_q   <= 1'b0;
            dac_n_q <= 1'b1;
        end else if (accept) begin
            res_q   <= conv_res;
            cmp_q   <= cmp_flag;
            dac_n_q <= dac_moved_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rdy_n_q <= 1'b1;
        else if (res_rd)
            rdy_n_q <= 1'b1;
        else if (accept)
            rdy_n_q <= 1'b0;
    end

    // R3: an accepted conversion clears ready
    p_accept_clears_rdy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && !hold) |=> !rdy_n_q);
    // R7: a result read sets ready
    p_read_sets_rdy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        res_rd |=> rdy_n_q);
    // R8: the result is frozen while held
    p_frozen_result_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> ($stable(res_q) && $stable(cmp_q) && $stable(dac_n_q)));
endmodule

// File: rtl/sreg_bank.sv
module sreg_bank
    import sreg_pkg::*;
#(
    parameter int unsigned RES_W  = 12,
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_done,
    input  logic [RES_W-1:0]  conv_res,
    input  logic              cmp_flag,
    input  logic              dac_moved_n,
    input  logic              pwr_down,
    input  logic              ptr_load,
    input  logic [ADDR_W-1:0] ptr_addr,
    input  logic              byte_rd,
    input  logic              xfer_end,
    output logic [BYTE_W-1:0] rd_byte
);
    localparam int unsigned WORD_W = 2 * BYTE_W;
    localparam int unsigned PAD_W  = WORD_W - RES_W;

    logic [ADDR_W-1:0] ptr;
    logic              step;
    logic              res_sel;
    logic              res_rd;
    logic              hold;
    logic [RES_W-1:0]  res_q;
    logic              rdy_n_q, cmp_q, dac_n_q;
    logic [WORD_W-1:0] word;
    logic [BYTE_W-1:0] status;

    assign step    = byte_rd && !ptr_load;
    assign res_sel = (ptr == ADDR_W'(ADR_RES_HI)) || (ptr == ADDR_W'(ADR_RES_LO));
    assign res_rd  = step && res_sel;

    sreg_ptr #(.ADDR_W(ADDR_W)) ptr_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ptr_load),
        .load_addr (ptr_addr),
        .step      (step),
        .ptr       (ptr)
    );

    sreg_hold_fsm fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .res_rd   (res_rd),
        .xfer_end (xfer_end),
        .hold     (hold)
    );

    sreg_store #(.RES_W(RES_W)) store_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .conv_done   (conv_done),
        .conv_res    (conv_res),
        .cmp_flag    (cmp_flag),
        .dac_moved_n (dac_moved_n),
        .hold        (hold),
        .res_rd      (res_rd),
        .res_q       (res_q),
        .rdy_n_q     (rdy_n_q),
        .cmp_q       (cmp_q),
        .dac_n_q     (dac_n_q)
    );

    assign word   = {res_q, {PAD_W{1'b0}}};
    assign status = {pwr_down, 1'b1, 1'b0, dac_n_q, cmp_q, 1'b0, 1'b1, rdy_n_q};

    always_comb begin
        if (ptr == ADDR_W'(ADR_STATUS))
            rd_byte = status;
        else if (ptr == ADDR_W'(ADR_RES_HI))
            rd_byte = word[WORD_W-1 -: BYTE_W];
        else if (ptr == ADDR_W'(ADR_RES_LO))
            rd_byte = word[BYTE_W-1:0];
        else
            rd_byte = '0;
    end

    // R10: unmapped addresses read zero
    p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr > ADDR_W'(ADR_RES_LO)) |-> (rd_byte == '0));
endmodule

// File: tb/sreg_bank_tb.sv
module sreg_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        conv_done = 1'b0;
    logic [11:0] conv_res = '0;
    logic        cmp_flag = 1'b0;
    logic        dac_moved_n = 1'b1;
    logic        pwr_down = 1'b0;
    logic        ptr_load = 1'b0;
    logic [7:0]  ptr_addr = '0;
    logic        byte_rd = 1'b0;
    logic        xfer_end = 1'b0;
    logic [7:0]  rd_byte;

    int errors = 0;
    int checks = 0;
    logic [7:0] b;

    always #5 clk = ~clk;

    sreg_bank dut_i (
        .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_res(conv_res),
        .cmp_flag(cmp_flag), .dac_moved_n(dac_moved_n), .pwr_down(pwr_down),
        .ptr_load(ptr_load), .ptr_addr(ptr_addr), .byte_rd(byte_rd),
        .xfer_end(xfer_end), .rd_byte(rd_byte)
    );

    // {result, cmp, dac_n}
    localparam logic [13:0] VEC [4] = '{
        {12'h300, 1'b0, 1'b1},
        {12'h800, 1'b1, 1'b0},
        {12'hCFF, 1'b0, 1'b1},
        {12'hFFF, 1'b1, 1'b0}
    };

    function automatic logic [7:0] stat(logic pd, logic d, logic c, logic r);
        return {pd, 1'b1, 1'b0, d, c, 1'b0, 1'b1, r};
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic conv(logic [11:0] r, logic c, logic d);
        @(negedge clk);
        conv_done = 1'b1; conv_res = r; cmp_flag = c; dac_moved_n = d;
        @(negedge clk);
        conv_done = 1'b0;
    endtask

    task automatic load(logic [7:0] a);
        @(negedge clk);
        ptr_load = 1'b1; ptr_addr = a;
        @(negedge clk);
        ptr_load = 1'b0;
    endtask

    task automatic rd(output logic [7:0] v);
        @(negedge clk);
        v = rd_byte;
        byte_rd = 1'b1;
        @(negedge clk);
        byte_rd = 1'b0;
    endtask

    task automatic stop();
        @(negedge clk);
        xfer_end = 1'b1;
        @(negedge clk);
        xfer_end = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset values
        check("R1 status", rd_byte, 8'h53);
        load(8'h01); check("R1 res hi", rd_byte, 8'h00);
        load(8'h02); check("R1 res lo", rd_byte, 8'h00);

        // vector table: R2 R3 R4 R7 R9
        for (int i = 0; i < 4; i++) begin
            logic [11:0] r;
            logic c, d;
            {r, c, d} = VEC[i];
            conv(r, c, d);
            load(8'h00);
            check("R2/R3/R4 status after conv", rd_byte, stat(1'b0, d, c, 1'b0));
            rd(b);
            check("R6 byte at 0x00", b, stat(1'b0, d, c, 1'b0));
            rd(b); check("R3 result high", b, r[11:4]);
            rd(b); check("R3 result low", b, {r[3:0], 4'h0});
            stop();
            load(8'h00);
            check("R7 ready set by result read", rd_byte, stat(1'b0, d, c, 1'b1));
        end

        // R5 live power-down bit
        @(negedge clk); pwr_down = 1'b1; #1;
        check("R5 power-down bit", rd_byte, stat(1'b1, 1'b0, 1'b1, 1'b1));
        pwr_down = 1'b0;

        // R7 reading status alone leaves ready low
        conv(12'hA5C, 1'b0, 1'b1);
        load(8'h00);
        rd(b);
        load(8'h00);
        check("R7 status read keeps ready", rd_byte, 8'h52);

        // R6 load wins over read
        @(negedge clk);
        ptr_load = 1'b1; ptr_addr = 8'h02; byte_rd = 1'b1;
        @(negedge clk);
        ptr_load = 1'b0; byte_rd = 1'b0;
        check("R6 load beats read", rd_byte, 8'hC0);
        load(8'h00);
        check("R6 ignored read leaves ready", rd_byte, 8'h52);

        // R8 conversion during hold is dropped
        load(8'h01);
        rd(b); check("R8 hi before hold", b, 8'hA5);
        conv(12'h123, 1'b1, 1'b0);
        rd(b); check("R8 lo from same sample", b, 8'hC0);
        load(8'h00);
        check("R8 status unchanged in hold", rd_byte, 8'h53);
        // R8 conversion coinciding with the end strobe is dropped
        @(negedge clk);
        xfer_end = 1'b1; conv_done = 1'b1; conv_res = 12'h777; cmp_flag = 1'b1;
        @(negedge clk);
        xfer_end = 1'b0; conv_done = 1'b0;
        load(8'h01);
        check("R8 end-cycle conversion dropped", rd_byte, 8'hA5);
        // R9 accepted after end
        conv(12'h3C4, 1'b1, 1'b0);
        check("R9 accepted after end", rd_byte, 8'h3C);
        stop();

        // R10 unmapped and R6 wrap
        load(8'h03); check("R10 address 0x03", rd_byte, 8'h00);
        load(8'hFF); check("R10 address 0xFF", rd_byte, 8'h00);
        rd(b);
        check("R6 wrap to status", rd_byte, stat(1'b0, 1'b0, 1'b1, 1'b0));

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule